// File: doc/BRIEF.md
# Serial connector routing crossbar

This block sits between three external serial connectors and three internal UART controllers. A 3-bit routing field in a small register file picks how the connectors are wired to the controllers. The block covers one mode in full, routing code 3'b011. In that mode the first UART has no flow-control pins, so the modem handshake of the first connector is handled by software. The incoming DCD, RI, DSR and CTS levels pass through a two-flop synchronizer and can then be read as status bits. The outgoing DTR and RTS levels come from writable control bits.

In the same mode the second connector serves only as a receive/transmit path for the FIFO UART. That controller's modem inputs are held inactive at 1. The third connector is always wired to the third UART. Every other routing code gives a plain default: each connector goes to its own UART, and the modem lines of the second connector pass straight through. The register file has two 8-bit locations. Writes use a one-cycle write strobe. Reads are combinational on the address.

Top module: `com_port_router`

## Requirements
- R1: After reset, location 0 reads 8'h00 (routing code 0), location 1 reads 8'h03 (DTR control bit 0 and RTS control bit 1 both at 1), and connector 1's DTR and RTS outputs are 1.
- R2: Location 0 bits [2:0] hold the routing code. A write with the strobe high updates them at the next rising clock edge, and they read back unchanged. Unused register bits read 0.
- R3: In every routing code, the first UART's receive input equals connector 1's Rx, and connector 1's Tx equals the first UART's transmit output. Both paths are combinational.
- R4: In every routing code, the third UART's receive input equals connector 3's Rx, and connector 3's Tx equals the third UART's transmit output.
- R5: In every routing code, the FIFO UART's receive input equals connector 2's Rx, and connector 2's Tx equals the FIFO UART's transmit output.
- R6: With routing code 3'b011, the FIFO UART's DCD, RI, DSR and CTS inputs are 1, and connector 2's DTR and RTS outputs are 1, whatever levels appear on the other side.
- R7: With routing code 3'b011, location 0 bit 7 reads connector 1's DCD, bit 6 reads RI, bit 5 reads DSR, and location 1 bit 4 reads CTS. Each status bit shows a pin level two rising edges after the pin changes, and not after only one edge.
- R8: With routing code 3'b011, connector 1's DTR output follows location 1 bit 0 and its RTS output follows location 1 bit 1. Both follow from the edge that completes the write.
- R9: The status bits are read-only. Writing any value to location 0 bits [7:5] or to location 1 bit 4 leaves their read values unchanged.
- R10: With any routing code other than 3'b011, the FIFO UART's DCD, RI, DSR and CTS inputs equal connector 2's, and connector 2's DTR and RTS equal the FIFO UART's. The status bits read 0, and connector 1's DTR and RTS outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register location select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| c1_rx | input | 1 | Connector 1 receive line |
| c1_tx | output | 1 | Connector 1 transmit line |
| c1_dcd | input | 1 | Connector 1 carrier detect |
| c1_ri | input | 1 | Connector 1 ring indicator |
| c1_dsr | input | 1 | Connector 1 data set ready |
| c1_cts | input | 1 | Connector 1 clear to send |
| c1_dtr | output | 1 | Connector 1 data terminal ready |
| c1_rts | output | 1 | Connector 1 request to send |
| c2_rx | input | 1 | Connector 2 receive line |
| c2_tx | output | 1 | Connector 2 transmit line |
| c2_dcd | input | 1 | Connector 2 carrier detect |
| c2_ri | input | 1 | Connector 2 ring indicator |
| c2_dsr | input | 1 | Connector 2 data set ready |
| c2_cts | input | 1 | Connector 2 clear to send |
| c2_dtr | output | 1 | Connector 2 data terminal ready |
| c2_rts | output | 1 | Connector 2 request to send |
| c3_rx | input | 1 | Connector 3 receive line |
| c3_tx | output | 1 | Connector 3 transmit line |
| ua_rxd | output | 1 | First UART receive input |
| ua_txd | input | 1 | First UART transmit output |
| uf_rxd | output | 1 | FIFO UART receive input |
| uf_txd | input | 1 | FIFO UART transmit output |
| uf_dcd | output | 1 | FIFO UART carrier detect input |
| uf_ri | output | 1 | FIFO UART ring indicator input |
| uf_dsr | output | 1 | FIFO UART data set ready input |
| uf_cts | output | 1 | FIFO UART clear to send input |
| uf_dtr | input | 1 | FIFO UART data terminal ready output |
| uf_rts | input | 1 | FIFO UART request to send output |
| uc_rxd | output | 1 | Third UART receive input |
| uc_txd | input | 1 | Third UART transmit output |

## Verification
The routing paths and the forced modem levels are combinational. The bench therefore samples them one time unit after driving the pins, within the same low clock phase. Register writes take effect at the rising edge between the strobe and the next falling edge, so readbacks and DTR/RTS levels are checked at that falling edge. A status bit needs two rising edges after its pin changes. The bench changes the pins at a falling edge and reads once after one rising edge, where it expects the old value. It reads again after the second rising edge, where it expects the new value.

// File: rtl/com_port_router.sv
module com_port_router #(
  parameter int DW = 8,
  parameter int MW = 3,
  parameter logic [2:0] EMU_MODE = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          c1_rx,
  output logic          c1_tx,
  input  logic          c1_dcd,
  input  logic          c1_ri,
  input  logic          c1_dsr,
  input  logic          c1_cts,
  output logic          c1_dtr,
  output logic          c1_rts,
  input  logic          c2_rx,
  output logic          c2_tx,
  input  logic          c2_dcd,
  input  logic          c2_ri,
  input  logic          c2_dsr,
  input  logic          c2_cts,
  output logic          c2_dtr,
  output logic          c2_rts,
  input  logic          c3_rx,
  output logic          c3_tx,
  output logic          ua_rxd,
  input  logic          ua_txd,
  output logic          uf_rxd,
  input  logic          uf_txd,
  output logic          uf_dcd,
  output logic          uf_ri,
  output logic          uf_dsr,
  output logic          uf_cts,
  input  logic          uf_dtr,
  input  logic          uf_rts,
  output logic          uc_rxd,
  input  logic          uc_txd
);
  localparam int NSYNC = 4;

  logic [MW-1:0]    mode_q;
  logic [1:0]       ctrl_q;
  logic [NSYNC-1:0] sync1_q, sync2_q;
  logic             emu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= 2'b11;
    end else if (reg_wr) begin
      if (!reg_addr) mode_q <= reg_wdata[MW-1:0];
      else           ctrl_q <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {c1_dcd, c1_ri, c1_dsr, c1_cts};
      sync2_q <= sync1_q;
    end
  end

  assign emu = (mode_q == EMU_MODE);

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[MW-1:0] = mode_q;
      if (emu) reg_rdata[7:5] = sync2_q[3:1];
    end else begin
      reg_rdata[1:0] = ctrl_q;
      if (emu) reg_rdata[4] = sync2_q[0];
    end
  end

  assign ua_rxd = c1_rx;
  assign c1_tx  = ua_txd;
  assign uf_rxd = c2_rx;
  assign c2_tx  = uf_txd;
  assign uc_rxd = c3_rx;
  assign c3_tx  = uc_txd;

  assign c1_dtr = emu ? ctrl_q[0] : 1'b1;
  assign c1_rts = emu ? ctrl_q[1] : 1'b1;

  assign {uf_dcd, uf_ri, uf_dsr, uf_cts} = emu ? 4'hF : {c2_dcd, c2_ri, c2_dsr, c2_cts};
  assign {c2_dtr, c2_rts} = emu ? 2'b11 : {uf_dtr, uf_rts};
endmodule

module com_port_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [2:0] mode_q,
  input logic [3:0] sync2_q,
  input logic       c1_dcd, c1_ri, c1_dsr, c1_cts,
  input logic       c1_rx, c1_tx, ua_rxd, ua_txd,
  input logic       c3_rx, c3_tx, uc_rxd, uc_txd,
  input logic       c1_dtr, c1_rts,
  input logic       c2_dcd, c2_ri, c2_dsr, c2_cts, c2_dtr, c2_rts,
  input logic       uf_dcd, uf_ri, uf_dsr, uf_cts, uf_dtr, uf_rts
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;

  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (mode_q == $past(reg_wdata[2:0])));

  p_com1_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_rxd == c1_rx) && (c1_tx == ua_txd));

  p_com3_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uc_rxd == c3_rx) && (c3_tx == uc_txd));

  p_fifo_tied_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b011) |-> ({uf_dcd, uf_ri, uf_dsr, uf_cts, c2_dtr, c2_rts} == 6'h3F));

  p_sync_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (sync2_q == $past({c1_dcd, c1_ri, c1_dsr, c1_cts}, 2)));

  p_ctrl_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && mode_q == 3'b011 && reg_wdata[2:0] == 3'b011) |=>
      (mode_q != 3'b011) || ({c1_rts, c1_dtr} == $past(reg_wdata[1:0])));

  p_default_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b011) |->
      ({uf_dcd, uf_ri, uf_dsr, uf_cts, c2_dtr, c2_rts, c1_dtr, c1_rts} ==
       {c2_dcd, c2_ri, c2_dsr, c2_cts, uf_dtr, uf_rts, 2'b11}));
endmodule

bind com_port_router com_port_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mode_q(mode_q), .sync2_q(sync2_q),
  .c1_dcd(c1_dcd), .c1_ri(c1_ri), .c1_dsr(c1_dsr), .c1_cts(c1_cts),
  .c1_rx(c1_rx), .c1_tx(c1_tx), .ua_rxd(ua_rxd), .ua_txd(ua_txd),
  .c3_rx(c3_rx), .c3_tx(c3_tx), .uc_rxd(uc_rxd), .uc_txd(uc_txd),
  .c1_dtr(c1_dtr), .c1_rts(c1_rts),
  .c2_dcd(c2_dcd), .c2_ri(c2_ri), .c2_dsr(c2_dsr), .c2_cts(c2_cts), .c2_dtr(c2_dtr), .c2_rts(c2_rts),
  .uf_dcd(uf_dcd), .uf_ri(uf_ri), .uf_dsr(uf_dsr), .uf_cts(uf_cts), .uf_dtr(uf_dtr), .uf_rts(uf_rts)
);

// File: tb/sim_com_port_router.sv
module sim_com_port_router;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic c1_rx = 0, c1_dcd = 0, c1_ri = 0, c1_dsr = 0, c1_cts = 0;
  logic c2_rx = 0, c2_dcd = 0, c2_ri = 0, c2_dsr = 0, c2_cts = 0;
  logic c3_rx = 0, ua_txd = 0, uf_txd = 0, uc_txd = 0, uf_dtr = 0, uf_rts = 0;
  logic c1_tx, c1_dtr, c1_rts, c2_tx, c2_dtr, c2_rts, c3_tx;
  logic ua_rxd, uf_rxd, uf_dcd, uf_ri, uf_dsr, uf_cts, uc_rxd;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  com_port_router u0 (.*);

  // {mode[2:0], in[11:0], exp[11:0]}
  // in  = {c1_rx,c2_rx,c3_rx, ua_txd,uf_txd,uc_txd, c2_dcd,c2_ri,c2_dsr,c2_cts, uf_dtr,uf_rts}
  // exp = {c1_tx,c2_tx,c3_tx, ua_rxd,uf_rxd,uc_rxd, uf_dcd,uf_ri,uf_dsr,uf_cts, c2_dtr,c2_rts}
  localparam logic [26:0] VEC [8] = '{
    {3'd0, 12'b101_010_1010_01, 12'b010_101_1010_01},
    {3'd0, 12'b010_101_0101_10, 12'b101_010_0101_10},
    {3'd3, 12'b110_001_0000_00, 12'b001_110_1111_11},
    {3'd3, 12'b001_110_1010_10, 12'b110_001_1111_11},
    {3'd5, 12'b111_000_1100_11, 12'b000_111_1100_11},
    {3'd7, 12'b000_111_0011_00, 12'b111_000_0011_00},
    {3'd2, 12'b100_011_1111_11, 12'b011_100_1111_11},
    {3'd4, 12'b011_100_0000_00, 12'b100_011_0000_00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [11:0] ob;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk("R1 loc0", d, 8'h00);
    rd(1, d); chk("R1 loc1", d, 8'h03);
    chk("R1 dtr/rts", {c1_dtr, c1_rts}, 2'b11);

    for (int i = 0; i < 8; i++) begin
      wr(0, {5'b0, VEC[i][26:24]});
      rd(0, d); chk("R2 mode readback", d, {5'b0, VEC[i][26:24]});
      {c1_rx, c2_rx, c3_rx, ua_txd, uf_txd, uc_txd, c2_dcd, c2_ri, c2_dsr, c2_cts, uf_dtr, uf_rts} = VEC[i][23:12];
      #1;
      ob = {c1_tx, c2_tx, c3_tx, ua_rxd, uf_rxd, uc_rxd, uf_dcd, uf_ri, uf_dsr, uf_cts, c2_dtr, c2_rts};
      chk("R3 com1 path", ob[11], VEC[i][11]);
      chk("R3 com1 rx", ob[8], VEC[i][8]);
      chk("R5 com2 path", {ob[10], ob[7]}, {VEC[i][10], VEC[i][7]});
      chk("R4 com3 path", {ob[9], ob[6]}, {VEC[i][9], VEC[i][6]});
      if (VEC[i][26:24] == 3'd3) chk("R6 fifo modem tied", ob[5:0], VEC[i][5:0]);
      else                       chk("R10 modem passthrough", ob[5:0], VEC[i][5:0]);
    end

    wr(0, 8'h03);
    wr(1, 8'h00); chk("R8 dtr/rts low", {c1_dtr, c1_rts}, 2'b00);
    wr(1, 8'h02); chk("R8 rts only", {c1_dtr, c1_rts}, 2'b01);
    wr(1, 8'h01); chk("R8 dtr only", {c1_dtr, c1_rts}, 2'b10);

    @(negedge clk);
    {c1_dcd, c1_ri, c1_dsr, c1_cts} = 4'b1011;
    @(posedge clk); @(negedge clk);
    rd(0, d); chk("R7 one edge loc0", d, 8'h03);
    rd(1, d); chk("R7 one edge loc1", d, 8'h01);
    @(posedge clk); @(negedge clk);
    rd(0, d); chk("R7 dcd/ri/dsr", d, 8'hA3);
    rd(1, d); chk("R7 cts", d, 8'h11);

    wr(1, 8'h01);
    rd(1, d); chk("R9 cts ro", d, 8'h11);
    wr(0, 8'h03);
    rd(0, d); chk("R9 loc0 status ro zero", d, 8'hA3);
    {c1_dcd, c1_ri, c1_dsr, c1_cts} = 4'b0000;
    repeat (3) @(negedge clk);
    wr(0, 8'hE3);
    rd(0, d); chk("R9 loc0 status ro ones", d, 8'h03);
    wr(1, 8'hFC);
    rd(1, d); chk("R9 loc1 ro", d, 8'h00);

    {c1_dcd, c1_ri, c1_dsr, c1_cts} = 4'b1111;
    wr(0, 8'h06);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R10 status zero loc0", d, 8'h06);
    rd(1, d); chk("R10 status zero loc1", d, 8'h00);
    chk("R10 com1 dtr/rts inactive", {c1_dtr, c1_rts}, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule